// File: doc/BRIEF.md
# Speed-Dependent Display Busy Timer

This block holds one 8-bit configuration byte and runs a busy timer for a display interface. Each time the core strobes a write to the display, a ready flag drops low. It stays low for a number of core clock cycles and then rises again. The length of that interval depends on the CPU speed mode in force when the strobe arrives. The byte is split into three delay fields, one for each of the fast speed modes. In the slowest mode a fixed base delay applies.

A field value n gives an interval of BASE + STEP·n cycles. The defaults are BASE = 48 and STEP = 64, so a 2-bit field covers 48 to 240 cycles and a 3-bit field covers 48 to 496 cycles. Software can write the byte at any time and can read it back. The display controller itself, the source of the speed mode and any clock switching all live outside this block.

Top module: `lcd_busy_delay`

## Requirements
- R1: After reset the configuration byte reads RESET_VAL (default 8'h4A) and lcdReady is high.
- R2: A cycle with cfgWrEn high loads cfgWrData into the byte. From the next cycle cfgRdData shows the byte, and it holds that value while cfgWrEn stays low.
- R3: When lcdWrStb is sampled high at a clock edge, lcdReady is low from that edge onward for exactly D cycles and then goes high. D is the delay selected at that edge.
- R4: With speedMode = 1, D = 48 + 64·byte[1:0].
- R5: With speedMode = 2, D = 48 + 64·byte[4:2].
- R6: With speedMode = 3, D = 48 + 64·byte[7:5].
- R7: With speedMode = 0, D is the fixed base of 48 cycles, whatever the byte holds.
- R8: A strobe that arrives while the timer is running restarts it from the full D. That D is chosen by the speed mode at the new strobe.
- R9: A change of speedMode while the timer is running does not alter the interval already in progress.
- R10: A write to the byte while the timer is running does not alter the interval in progress. A write in the same cycle as a strobe leaves that strobe using the previous byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; delays are counted in its cycles |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Write enable for the configuration byte |
| cfgWrData | input | 8 | Data for the configuration byte |
| cfgRdData | output | 8 | Current configuration byte |
| speedMode | input | 2 | Current CPU speed mode, 0 to 3 |
| lcdWrStb | input | 1 | One strobe per display write |
| lcdReady | output | 1 | High when the display may be written again |

## Verification
The assertions assume that every input is synchronous to clk and settled at each rising edge. They also assume that speedMode is a plain 2-bit value whose meaning is taken only at the strobe edge. The bench drives every input on the falling edge, so each value is stable across the next rising edge. It then moves speedMode, the configuration byte and repeated strobes freely during a running interval, to confirm that only the strobe edge matters.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  // Field placement inside the configuration byte, one field per fast mode
  localparam int CFG_W    = 8;
  localparam int M1_LSB   = 0;
  localparam int M1_W     = 2;
  localparam int M2_LSB   = 2;
  localparam int M2_W     = 3;
  localparam int M3_LSB   = 5;
  localparam int M3_W     = 3;
  localparam int MAX_FIELD = (1 << M3_W) - 1;

  typedef enum logic [1:0] {
    MODE_BASE = 2'd0,
    MODE_ONE  = 2'd1,
    MODE_TWO  = 2'd2,
    MODE_TRI  = 2'd3
  } speed_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic regWrite;
    logic loadTimer;
    logic tickTimer;
  } lbd_ctrl_t;
endpackage

// File: rtl/lbd_ctrl.sv
module lbd_ctrl
  import lbd_pkg::*;
(
  input  logic      cfgWrEn,
  input  logic      lcdWrStb,
  input  logic      timerBusy,
  output lbd_ctrl_t ctrl
);
  // A strobe always wins over counting so a retrigger restarts the count
  always_comb begin
    ctrl           = '0;
    ctrl.regWrite  = cfgWrEn;
    ctrl.loadTimer = lcdWrStb;
    ctrl.tickTimer = timerBusy && !lcdWrStb;
  end
endmodule

// File: rtl/lbd_datapath.sv
module lbd_datapath
  import lbd_pkg::*;
#(
  parameter logic [7:0] RESET_VAL  = 8'h4A,
  parameter int         BASE_DELAY = 48,
  parameter int         STEP_DELAY = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  lbd_ctrl_t        ctrl,
  input  logic [CFG_W-1:0] wrData,
  input  logic [1:0]       speedMode,
  output logic [CFG_W-1:0] cfgReg,
  output logic             timerBusy
);
  localparam int MAX_DELAY = BASE_DELAY + STEP_DELAY * MAX_FIELD;
  localparam int CW        = $clog2(MAX_DELAY + 1);

  logic [CW-1:0] timerCnt;
  logic [CW-1:0] delaySel;
  logic [M1_W-1:0] fieldOne;
  logic [M2_W-1:0] fieldTwo;
  logic [M3_W-1:0] fieldTri;

  assign fieldOne = cfgReg[M1_LSB +: M1_W];
  assign fieldTwo = cfgReg[M2_LSB +: M2_W];
  assign fieldTri = cfgReg[M3_LSB +: M3_W];

  // Pick the interval for the live speed mode
  always_comb begin
    case (speed_e'(speedMode))
      MODE_ONE: delaySel = CW'(BASE_DELAY + STEP_DELAY * int'(fieldOne));
      MODE_TWO: delaySel = CW'(BASE_DELAY + STEP_DELAY * int'(fieldTwo));
      MODE_TRI: delaySel = CW'(BASE_DELAY + STEP_DELAY * int'(fieldTri));
      default:  delaySel = CW'(BASE_DELAY);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= RESET_VAL;
    end else if (ctrl.regWrite) begin
      cfgReg <= wrData;
    end
  end

  // Down counter: ready is high exactly when it has drained
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerCnt <= '0;
    end else if (ctrl.loadTimer) begin
      timerCnt <= delaySel;
    end else if (ctrl.tickTimer) begin
      timerCnt <= timerCnt - CW'(1);
    end
  end

  assign timerBusy = (timerCnt != '0);
endmodule

// File: rtl/lcd_busy_delay.sv
module lcd_busy_delay #(
  parameter logic [7:0] RESET_VAL  = 8'h4A,
  parameter int         BASE_DELAY = 48,
  parameter int         STEP_DELAY = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [7:0] cfgWrData,
  output logic [7:0] cfgRdData,
  input  logic [1:0] speedMode,
  input  logic       lcdWrStb,
  output logic       lcdReady
);
  import lbd_pkg::*;

  lbd_ctrl_t ctrl;
  logic      timerBusy;

  lbd_ctrl u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .lcdWrStb  (lcdWrStb),
    .timerBusy (timerBusy),
    .ctrl      (ctrl)
  );

  lbd_datapath #(
    .RESET_VAL  (RESET_VAL),
    .BASE_DELAY (BASE_DELAY),
    .STEP_DELAY (STEP_DELAY)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .wrData    (cfgWrData),
    .speedMode (speedMode),
    .cfgReg    (cfgRdData),
    .timerBusy (timerBusy)
  );

  assign lcdReady = !timerBusy;
endmodule

// File: rtl/lbd_chk.sv
module lbd_chk #(
  parameter int BASE_DELAY = 48,
  parameter int STEP_DELAY = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWrEn,
  input logic [7:0] cfgWrData,
  input logic [7:0] cfgRdData,
  input logic [1:0] speedMode,
  input logic       lcdWrStb,
  input logic       lcdReady
);
  logic [10:0] elapsed;
  logic [10:0] expLen;

  function automatic logic [10:0] lenFor(logic [7:0] b, logic [1:0] m);
    case (m)
      2'd1:    return 11'(BASE_DELAY + STEP_DELAY * int'(b[1:0]));
      2'd2:    return 11'(BASE_DELAY + STEP_DELAY * int'(b[4:2]));
      2'd3:    return 11'(BASE_DELAY + STEP_DELAY * int'(b[7:5]));
      default: return 11'(BASE_DELAY);
    endcase
  endfunction

  // Length of the current low phase, measured at the ports
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsed <= '0;
      expLen  <= '0;
    end else if (lcdWrStb) begin
      elapsed <= '0;
      expLen  <= lenFor(cfgRdData, speedMode);
    end else if (!lcdReady) begin
      elapsed <= elapsed + 11'd1;
    end
  end

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    lcdWrStb |=> !lcdReady);

  // R4 R5 R6 R7 R9 R10
  low_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lcdReady) |-> elapsed == expLen);

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData == $past(cfgWrData));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(cfgRdData));

  // R3
  no_stray_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lcdReady && !lcdWrStb) |=> lcdReady);
endmodule

bind lcd_busy_delay lbd_chk #(
  .BASE_DELAY (BASE_DELAY),
  .STEP_DELAY (STEP_DELAY)
) u_lbd_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .cfgRdData (cfgRdData),
  .speedMode (speedMode),
  .lcdWrStb  (lcdWrStb),
  .lcdReady  (lcdReady)
);

// File: tb/test_lcd_busy_delay.sv
`timescale 1ns/1ps
module test_lcd_busy_delay;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic [1:0] speedMode = '0;
  logic       lcdWrStb = 1'b0;
  logic       lcdReady;

  int runCnt = 0;
  int failCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_busy_delay i_lcd_busy_delay (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .speedMode(speedMode), .lcdWrStb(lcdWrStb),
    .lcdReady(lcdReady)
  );

  function automatic int expDelay(logic [7:0] b, logic [1:0] m);
    case (m)
      2'd1:    return 48 + 64 * int'(b[1:0]);
      2'd2:    return 48 + 64 * int'(b[4:2]);
      2'd3:    return 48 + 64 * int'(b[7:5]);
      default: return 48;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    runCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCfg(logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Strobe on one edge; optional changes one cycle later; count low samples
  task automatic strobeAndCount(logic [1:0] m, output int lowLen,
                                input bit midMode, input logic [1:0] newMode,
                                input bit midWrite, input logic [7:0] newVal);
    @(negedge clk);
    speedMode = m; lcdWrStb = 1'b1;
    @(negedge clk);
    lcdWrStb = 1'b0;
    lowLen = 0;
    if (!lcdReady) lowLen = 1;
    if (midMode) speedMode = newMode;
    if (midWrite) begin cfgWrEn = 1'b1; cfgWrData = newVal; end
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      cfgWrEn = 1'b0;
      if (lcdReady) break;
      lowLen++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog R3 actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] v;
    logic [1:0] m;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset byte", int'(cfgRdData), 8'h4A);
    check("R1 reset ready", int'(lcdReady), 1);
    rstN = 1'b1;
    @(negedge clk);

    // R7 base mode with default byte and with a full byte
    strobeAndCount(2'd0, n, 0, 2'd0, 0, 8'h0);
    check("R7 mode0 default", n, 48);
    writeCfg(8'hFF);
    // R2 readback
    check("R2 readback FF", int'(cfgRdData), 8'hFF);
    strobeAndCount(2'd0, n, 0, 2'd0, 0, 8'h0);
    check("R7 mode0 ignores byte", n, 48);

    // R4 every value of the mode-1 field
    for (int f = 0; f < 4; f++) begin
      writeCfg(8'(f) | 8'hFC);
      strobeAndCount(2'd1, n, 0, 2'd0, 0, 8'h0);
      check($sformatf("R4 mode1 field %0d", f), n, 48 + 64 * f);
    end
    // R5 and R6 every value of the 3-bit fields
    for (int f = 0; f < 8; f++) begin
      writeCfg(8'(f << 2) | 8'(((7 - f) << 5)));
      strobeAndCount(2'd2, n, 0, 2'd0, 0, 8'h0);
      check($sformatf("R5 mode2 field %0d", f), n, 48 + 64 * f);
      strobeAndCount(2'd3, n, 0, 2'd0, 0, 8'h0);
      check($sformatf("R6 mode3 field %0d", 7 - f), n, 48 + 64 * (7 - f));
    end

    // R9 mode change mid-interval
    writeCfg(8'b011_101_10);
    strobeAndCount(2'd3, n, 1, 2'd0, 0, 8'h0);
    check("R9 mode change mid", n, 48 + 64 * 3);
    // R10 byte write mid-interval
    strobeAndCount(2'd2, n, 0, 2'd0, 1, 8'h00);
    check("R10 write mid", n, 48 + 64 * 5);
    check("R2 readback after mid write", int'(cfgRdData), 0);

    // R10 same-cycle write and strobe uses old byte
    @(negedge clk);
    speedMode = 2'd3; lcdWrStb = 1'b1; cfgWrEn = 1'b1; cfgWrData = 8'hE0;
    @(negedge clk);
    lcdWrStb = 1'b0; cfgWrEn = 1'b0;
    n = lcdReady ? 0 : 1;
    while (!lcdReady && n < 2000) begin @(negedge clk); if (!lcdReady) n++; end
    check("R10 same-cycle write", n, 48);
    check("R2 same-cycle readback", int'(cfgRdData), 8'hE0);

    // R8 retrigger after 30 cycles with another mode
    writeCfg(8'b111_010_01);
    @(negedge clk);
    speedMode = 2'd1; lcdWrStb = 1'b1;
    @(negedge clk);
    lcdWrStb = 1'b0;
    repeat (30) @(negedge clk);
    strobeAndCount(2'd3, n, 0, 2'd0, 0, 8'h0);
    check("R8 retrigger full count", n, 48 + 64 * 7);

    // R8 strobes on back-to-back cycles
    @(negedge clk);
    speedMode = 2'd2; lcdWrStb = 1'b1;
    strobeAndCount(2'd1, n, 0, 2'd0, 0, 8'h0);
    check("R8 back-to-back", n, 112);

    // Random mix, fixed seed
    void'($urandom(32'h1D5A));
    for (int i = 0; i < 40; i++) begin
      v = 8'($urandom);
      m = 2'($urandom);
      writeCfg(v);
      check("R2 random readback", int'(cfgRdData), int'(v));
      strobeAndCount(m, n, 1'($urandom), 2'($urandom), 1'($urandom), 8'($urandom));
      check($sformatf("R3 random mode %0d", m), n, expDelay(v, m));
    end

    check("R3 ready after run", int'(lcdReady), 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule